// File: doc/BRIEF.md
# Platform Interrupt Controller Register Block

This block gathers 64 interrupt sources and gives each one a dedicated output line. Each source can be configured through memory-mapped registers. A source can be inverted, which selects its active level, and it can be level or edge sensitive. Each source can also be masked off. Edge-sensitive sources keep a pending flag until software clears it. In-service bookkeeping drives a status word, which reports only the sources that are delivered and not masked. Two 64-byte tables are also part of the block: one holds per-source routing entries and the other holds message vectors. Other logic reads these tables, and the block only stores them.

Software uses a single request port. A request can be 1, 2, 4 or 8 bytes wide and must be naturally aligned. The three low address bits pick the byte lanes inside a 64-bit register word. Data is little-endian. Every request gets exactly one response on the following cycle. Reads return the selected lanes moved down to bit 0. Writes change only the lanes that the request names.

Top module: `pic_regblock`

## Requirements
- R1: After reset the mask word is all ones. The trigger, message-enable and inversion words, both tables, the pending state and the in-service state are all zero, and `irq_out` is zero.
- R2: The register word map uses byte addresses. Identity is at 0x000, mask at 0x020, trigger at 0x040 (1 = edge), clear at 0x060, message-enable at 0x080, the two inert control words at 0x0A0 and 0x0C0, status at 0x100 and inversion at 0x120. A read returns the word shifted right by 8×`req_addr[2:0]` and truncated to `req_size` bytes.
- R3: A write replaces only the addressed byte lanes of the word. All other lanes keep their old value.
- R4: A `req_size` outside {1,2,4,8}, or an address that is not a multiple of the size, is an error. The response then has `rsp_err`=1 and `rsp_rdata`=0, and no state changes. `rsp_err` is 0 for every other response.
- R5: Each request cycle produces exactly one `rsp_valid` pulse on the next cycle. Write responses carry zero data.
- R6: `irq_out[i]` is high exactly when source i is pending and its mask bit is 0. Setting the mask bit drops the output. Clearing it raises the output again if the source is still pending.
- R7: The effective input is `irq_in[i]` XOR the inversion bit, and the pending state follows it one clock later. For a level source the pending state equals the registered effective input. For an edge source, pending is set only on a 0-to-1 change of the effective input and is held after the input falls.
- R8: A write to the clear word clears the pending and in-service state of each written bit whose source is edge-triggered. Written bits of level sources are not affected. The clear word reads as zero.
- R9: The status word reads as in-service AND NOT mask. Writes to the status word are ignored.
- R10: The identity word is read-only. It holds the controller ID in bits 31:24, the version in bits 39:32 and the source count minus one (63) in bits 55:48. All other bits are zero.
- R11: Accesses to the two inert control words respond without error. Writes to them are discarded and reads return zero.
- R12: The routing table is at 0x200–0x23F and the vector table is at 0x300–0x33F. Byte n of a table is at base+n. Both tables follow the same read rules as R2 and the same merge rules as R3.
- R13: An access to any address outside the map responds without error. Its read data is zero and its write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 64 | Write data, least significant lanes used |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data, aligned to bit 0 |
| rsp_err | output | 1 | Illegal size or misalignment |
| irq_in | input | 64 | Raw interrupt inputs |
| irq_out | output | 64 | Per-source interrupt outputs |

## Verification
The assertions assume that `irq_in` is synchronous to `clk`. They also assume that the request fields are stable and defined whenever `req_valid` is high, and that at most one request arrives per cycle. The stimulus meets these conditions. It changes every input half a cycle away from the sampling edge, it issues each request alone, and it holds `req_valid` low during reset. The stimulus also keeps input edges away from clear writes, so a new edge and a clear never land on the same cycle. Their relative order is therefore never what decides a result.

// File: rtl/pic_pkg.sv
// Shared constants, register selector type and word-map offsets for the
// interrupt controller register block. Assumes 64 sources and 64-bit words.
package pic_pkg;
    localparam int WORD_W    = 64;
    localparam int SRC_CNT   = 64;
    localparam int TBL_BYTES = 64;
    localparam int TBL_WORDS = TBL_BYTES / (WORD_W / 8);
    localparam int TBL_IDX_W = $clog2(TBL_WORDS);

    localparam int OFS_IDENT  = 'h000;
    localparam int OFS_MASK   = 'h020;
    localparam int OFS_TRIG   = 'h040;
    localparam int OFS_CLEAR  = 'h060;
    localparam int OFS_MSGEN  = 'h080;
    localparam int OFS_INERT0 = 'h0A0;
    localparam int OFS_INERT1 = 'h0C0;
    localparam int OFS_STATUS = 'h100;
    localparam int OFS_INVERT = 'h120;
    localparam int OFS_ROUTE  = 'h200;
    localparam int OFS_VECTOR = 'h300;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_IDENT, SEL_MASK, SEL_TRIG, SEL_CLEAR, SEL_MSGEN,
        SEL_INERT, SEL_STATUS, SEL_INVERT, SEL_ROUTE, SEL_VECTOR
    } reg_sel_e;
endpackage

// File: rtl/pic_access_decode.sv
// Decodes one request: picks the target word, checks size and alignment,
// and produces the byte-lane mask and the shift for the addressed lanes.
// Assumes the address is a byte address and words are 8 bytes.
module pic_access_decode
    import pic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output logic              acc_ok,
    output reg_sel_e          sel,
    output logic [5:0]        shamt,
    output logic [WORD_W-1:0] size_mask,
    output logic [WORD_W-1:0] lane_mask
);
    localparam int WA_W = ADDR_W - 3;
    localparam int TA_W = ADDR_W - $clog2(TBL_BYTES);

    logic [WA_W-1:0] word_adr;
    logic [TA_W-1:0] tbl_adr;
    logic            aligned;

    assign word_adr = addr[ADDR_W-1:3];
    assign tbl_adr  = addr[ADDR_W-1:$clog2(TBL_BYTES)];
    assign shamt    = {addr[2:0], 3'b000};

    // Size legality, alignment and the unshifted lane mask.
    always_comb begin
        size_mask = '0;
        aligned   = 1'b0;
        case (size)
            4'd1: begin size_mask = 64'h0000_0000_0000_00FF; aligned = 1'b1; end
            4'd2: begin size_mask = 64'h0000_0000_0000_FFFF; aligned = ~addr[0]; end
            4'd4: begin size_mask = 64'h0000_0000_FFFF_FFFF; aligned = (addr[1:0] == 2'b00); end
            4'd8: begin size_mask = '1;                       aligned = (addr[2:0] == 3'b000); end
            default: begin size_mask = '0; aligned = 1'b0; end
        endcase
    end

    assign acc_ok    = aligned;
    assign lane_mask = size_mask << shamt;

    // Map the word address onto a register selector.
    always_comb begin
        sel = SEL_NONE;
        if      (word_adr == WA_W'(OFS_IDENT  >> 3)) sel = SEL_IDENT;
        else if (word_adr == WA_W'(OFS_MASK   >> 3)) sel = SEL_MASK;
        else if (word_adr == WA_W'(OFS_TRIG   >> 3)) sel = SEL_TRIG;
        else if (word_adr == WA_W'(OFS_CLEAR  >> 3)) sel = SEL_CLEAR;
        else if (word_adr == WA_W'(OFS_MSGEN  >> 3)) sel = SEL_MSGEN;
        else if (word_adr == WA_W'(OFS_INERT0 >> 3)) sel = SEL_INERT;
        else if (word_adr == WA_W'(OFS_INERT1 >> 3)) sel = SEL_INERT;
        else if (word_adr == WA_W'(OFS_STATUS >> 3)) sel = SEL_STATUS;
        else if (word_adr == WA_W'(OFS_INVERT >> 3)) sel = SEL_INVERT;
        else if (tbl_adr  == TA_W'(OFS_ROUTE  >> $clog2(TBL_BYTES))) sel = SEL_ROUTE;
        else if (tbl_adr  == TA_W'(OFS_VECTOR >> $clog2(TBL_BYTES))) sel = SEL_VECTOR;
    end
endmodule

// File: rtl/pic_byte_table.sv
// Byte-addressable table held as 64-bit words; writes merge byte lanes.
// Assumes write data is already shifted into lanes and masked.
module pic_byte_table
    import pic_pkg::*;
#(
    parameter int WORDS = TBL_WORDS,
    parameter int IDX_W = TBL_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] lane_mask,
    input  logic [WORD_W-1:0] wdata_sh,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Hold one table word; merge the addressed lanes on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[w] <= '0;
            else if (wr_en && idx == IDX_W'(w))
                mem_q[w] <= (mem_q[w] & ~lane_mask) | wdata_sh;
        end
    end

    assign rd_word = mem_q[idx];
endmodule

// File: rtl/pic_src_tracker.sv
// Per-source pending and in-service tracking with inversion, edge or
// level sensing, clear and mask. Assumes irq_in is synchronous to clk.
module pic_src_tracker
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_CNT-1:0] irq_in,
    input  logic [SRC_CNT-1:0] invert,
    input  logic [SRC_CNT-1:0] trig_edge,
    input  logic [SRC_CNT-1:0] mask,
    input  logic [SRC_CNT-1:0] clr_req,
    output logic [SRC_CNT-1:0] irq_out,
    output logic [SRC_CNT-1:0] in_service
);
    logic [SRC_CNT-1:0] pend_q;
    logic [SRC_CNT-1:0] svc_q;
    logic [SRC_CNT-1:0] prev_q;

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
        logic eff;
        logic clr;
        assign eff = irq_in[i] ^ invert[i];
        assign clr = clr_req[i] & trig_edge[i];

        // Track the previous effective level, the pending flag and in-service.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
                svc_q[i]  <= 1'b0;
            end else begin
                prev_q[i] <= eff;
                if (trig_edge[i]) begin
                    pend_q[i] <= (pend_q[i] & ~clr) | (eff & ~prev_q[i]);
                    svc_q[i]  <= (svc_q[i] | (pend_q[i] & ~mask[i])) & ~clr;
                end else begin
                    pend_q[i] <= eff;
                    svc_q[i]  <= pend_q[i] & ~mask[i];
                end
            end
        end

        assign irq_out[i] = pend_q[i] & ~mask[i];
    end

    assign in_service = svc_q;
endmodule

// File: rtl/pic_regblock.sv
// Top of the interrupt controller register block: request port, control
// words, identity, two byte tables and the source tracker. Assumes one
// request per cycle; the response follows one cycle later.
module pic_regblock
    import pic_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] CTRL_ID  = 8'h07,
    parameter logic [7:0] CTRL_VER = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [3:0]         req_size,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    input  logic [SRC_CNT-1:0] irq_in,
    output logic [SRC_CNT-1:0] irq_out
);
    localparam logic [WORD_W-1:0] IDENT_WORD =
        {8'h00, 8'(SRC_CNT - 1), 8'h00, CTRL_VER, CTRL_ID, 24'h000000};

    logic              acc_ok;
    reg_sel_e          sel;
    logic [5:0]        shamt;
    logic [WORD_W-1:0] size_mask, lane_mask, wdata_sh, rd_word;
    logic [WORD_W-1:0] route_rd, vector_rd;
    logic [SRC_CNT-1:0] mask_q, trig_q, msgen_q, inv_q, in_service, clr_req;
    logic              wr_go;

    pic_access_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (req_addr),
        .size      (req_size),
        .acc_ok    (acc_ok),
        .sel       (sel),
        .shamt     (shamt),
        .size_mask (size_mask),
        .lane_mask (lane_mask)
    );

    assign wr_go    = req_valid & req_write & acc_ok;
    assign wdata_sh = (req_wdata << shamt) & lane_mask;
    assign clr_req  = (wr_go && sel == SEL_CLEAR) ? wdata_sh : '0;

    // Control words: lane-merged on a legal write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            trig_q  <= '0;
            msgen_q <= '0;
            inv_q   <= '0;
        end else if (wr_go) begin
            case (sel)
                SEL_MASK:   mask_q  <= (mask_q  & ~lane_mask) | wdata_sh;
                SEL_TRIG:   trig_q  <= (trig_q  & ~lane_mask) | wdata_sh;
                SEL_MSGEN:  msgen_q <= (msgen_q & ~lane_mask) | wdata_sh;
                SEL_INVERT: inv_q   <= (inv_q   & ~lane_mask) | wdata_sh;
                default: ;
            endcase
        end
    end

    pic_byte_table u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_go && sel == SEL_ROUTE),
        .idx       (req_addr[5:3]),
        .lane_mask (lane_mask),
        .wdata_sh  (wdata_sh),
        .rd_word   (route_rd)
    );

    pic_byte_table u_vector (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_go && sel == SEL_VECTOR),
        .idx       (req_addr[5:3]),
        .lane_mask (lane_mask),
        .wdata_sh  (wdata_sh),
        .rd_word   (vector_rd)
    );

    pic_src_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .invert     (inv_q),
        .trig_edge  (trig_q),
        .mask       (mask_q),
        .clr_req    (clr_req),
        .irq_out    (irq_out),
        .in_service (in_service)
    );

    // Select the full word addressed by the request.
    always_comb begin
        case (sel)
            SEL_IDENT:  rd_word = IDENT_WORD;
            SEL_MASK:   rd_word = mask_q;
            SEL_TRIG:   rd_word = trig_q;
            SEL_MSGEN:  rd_word = msgen_q;
            SEL_STATUS: rd_word = in_service & ~mask_q;
            SEL_INVERT: rd_word = inv_q;
            SEL_ROUTE:  rd_word = route_rd;
            SEL_VECTOR: rd_word = vector_rd;
            default:    rd_word = '0;
        endcase
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & ~acc_ok;
            rsp_rdata <= (req_valid && !req_write && acc_ok)
                         ? ((rd_word >> shamt) & size_mask) : '0;
        end
    end
endmodule

// File: rtl/pic_regblock_chk.sv
// Property checker for pic_regblock, attached by bind. Assumes synchronous
// inputs and defined request fields while req_valid is high.
module pic_regblock_chk #(
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] CTRL_ID  = 8'h07,
    parameter logic [7:0] CTRL_VER = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [63:0]       irq_out,
    input logic [63:0]       mask_q,
    input logic [63:0]       trig_q,
    input logic [63:0]       inv_q,
    input logic [63:0]       msgen_q
);
    logic legal;
    always_comb begin
        case (req_size)
            4'd1:    legal = 1'b1;
            4'd2:    legal = (req_addr[0] == 1'b0);
            4'd4:    legal = (req_addr[1:0] == 2'b00);
            4'd8:    legal = (req_addr[2:0] == 3'b000);
            default: legal = 1'b0;
        endcase
    end

    AST_MASK_ALL_SET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mask_q == '1); // R1
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R5
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R5
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R4
    AST_BAD_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |=> rsp_err); // R4
    AST_GOOD_ACCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && legal) |=> !rsp_err); // R4
    AST_BAD_WRITE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !legal) |=>
        ($stable(mask_q) && $stable(trig_q) && $stable(inv_q) && $stable(msgen_q))); // R4
    AST_MASKED_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask_q) == '0); // R6
    AST_IDENT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0 && req_size == 4'd8) |=>
        rsp_rdata == {8'h00, 8'd63, 8'h00, CTRL_VER, CTRL_ID, 24'h000000}); // R10
endmodule

bind pic_regblock pic_regblock_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ID  (CTRL_ID),
    .CTRL_VER (CTRL_VER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .trig_q    (trig_q),
    .inv_q     (inv_q),
    .msgen_q   (msgen_q)
);

// File: tb/test_pic_regblock.sv
// Scoreboard bench: the request task queues the expected response and a
// negedge monitor pops and compares every response the block returns.
module test_pic_regblock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [63:0] irq_in = '0;
    logic [63:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    pic_regblock i_pic_regblock (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_data.size() == 0) begin
                check("R5 unexpected response", 64'd1, 64'd0);
            end else begin
                check({q_tag[0], " data"}, rsp_rdata, q_data[0]);
                check({q_tag[0], " err"}, {63'd0, rsp_err}, {63'd0, q_err[0]});
                void'(q_data.pop_front());
                void'(q_err.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic access(input string tag, input logic wr, input logic [11:0] a,
                          input logic [3:0] sz, input logic [63:0] wd,
                          input logic [63:0] exp_d, input logic exp_e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        q_data.push_back(exp_d); q_err.push_back(exp_e); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [3:0] sz,
                      input logic [63:0] wd, input logic exp_e);
        access(tag, 1'b1, a, sz, wd, 64'd0, exp_e);
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [3:0] sz,
                      input logic [63:0] exp_d);
        access(tag, 1'b0, a, sz, 64'd0, exp_d, 1'b0);
    endtask

    task automatic drive_in(input logic [63:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    localparam logic [63:0] IDENT = 64'h003F_0001_0700_0000;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", irq_out, 64'd0);
        rst_n = 1'b1;
        check("R1 irq_out after reset", irq_out, 64'd0);
        rd("R1 mask reset",   12'h020, 4'd8, '1);
        rd("R1 trigger reset", 12'h040, 4'd8, 64'd0);
        rd("R1 invert reset", 12'h120, 4'd8, 64'd0);
        rd("R1 msgen reset",  12'h080, 4'd8, 64'd0);
        rd("R10 ident word",  12'h000, 4'd8, IDENT);
        // R2 sub-word reads
        rd("R2 ident byte3",  12'h003, 4'd1, 64'h07);
        rd("R2 ident byte6",  12'h006, 4'd1, 64'h3F);
        rd("R2 ident half2",  12'h004, 4'd2, 64'h0001);
        rd("R2 mask upper",   12'h024, 4'd4, 64'hFFFF_FFFF);
        // R3 lane merge
        wr("R3 invert full",  12'h120, 4'd8, 64'h1122_3344_5566_7788, 1'b0);
        wr("R3 invert half",  12'h122, 4'd2, 64'hFFFF_FFFF_FFFF_ABCD, 1'b0);
        rd("R3 invert merged", 12'h120, 4'd8, 64'h1122_3344_ABCD_7788);
        wr("R3 invert top byte", 12'h127, 4'd1, 64'hEE, 1'b0);
        rd("R3 invert upper", 12'h124, 4'd4, 64'hEE22_3344);
        wr("R3 msgen byte",   12'h081, 4'd1, 64'h5C, 1'b0);
        rd("R3 msgen read",   12'h080, 4'd8, 64'h5C00);
        wr("R3 invert zero",  12'h120, 4'd8, 64'd0, 1'b0);
        // R4 illegal size and misalignment
        wr("R4 size3 write",  12'h020, 4'd3, 64'd0, 1'b1);
        rd("R4 mask kept",    12'h020, 4'd8, '1);
        access("R4 misaligned read", 1'b0, 12'h022, 4'd4, 64'd0, 64'd0, 1'b1);
        wr("R4 misaligned write", 12'h124, 4'd8, '1, 1'b1);
        rd("R4 invert kept",  12'h120, 4'd8, 64'd0);
        access("R4 size0 read", 1'b0, 12'h000, 4'd0, 64'd0, 64'd0, 1'b1);
        // R13 unmapped
        wr("R13 unmapped write", 12'h3F8, 4'd8, '1, 1'b0);
        rd("R13 unmapped read",  12'h3F8, 4'd8, 64'd0);
        // R11 inert words
        wr("R11 inert0 write", 12'h0A0, 4'd8, '1, 1'b0);
        rd("R11 inert0 read",  12'h0A0, 4'd8, 64'd0);
        wr("R11 inert1 write", 12'h0C4, 4'd4, '1, 1'b0);
        rd("R11 inert1 read",  12'h0C0, 4'd8, 64'd0);
        // R12 tables
        wr("R12 route byte5", 12'h205, 4'd1, 64'h5A, 1'b0);
        rd("R12 route word0", 12'h200, 4'd8, 64'h0000_5A00_0000_0000);
        wr("R12 vector word7", 12'h338, 4'd8, 64'h0102_0304_0506_0708, 1'b0);
        rd("R12 vector half", 12'h33A, 4'd2, 64'h0506);
        rd("R12 vector last", 12'h33F, 4'd1, 64'h01);
        rd("R12 route other word", 12'h238, 4'd8, 64'd0);
        // R10 read-only identity
        wr("R10 ident write", 12'h000, 4'd8, 64'd0, 1'b0);
        rd("R10 ident kept",  12'h000, 4'd8, IDENT);
        // R7 level source and R6 masking
        wr("R6 unmask low four", 12'h020, 4'd8, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0);
        drive_in(64'h1);
        check("R7 level follows high", irq_out, 64'h1);
        rd("R9 status level", 12'h100, 4'd8, 64'h1);
        drive_in(64'h0);
        check("R7 level follows low", irq_out, 64'h0);
        drive_in(64'h100);
        check("R6 masked source stays low", irq_out, 64'h0);
        drive_in(64'h0);
        // R7 inversion
        wr("R7 invert bit1", 12'h120, 4'd1, 64'h02, 1'b0);
        @(negedge clk);
        check("R7 inverted idle asserts", irq_out, 64'h2);
        wr("R7 invert off", 12'h120, 4'd1, 64'h00, 1'b0);
        @(negedge clk);
        check("R7 invert removed", irq_out, 64'h0);
        // R7 edge latch, R6 mask, R9 status, R8 clear
        wr("R7 trigger bit2 edge", 12'h040, 4'd1, 64'h04, 1'b0);
        drive_in(64'h4);
        check("R7 edge latched", irq_out, 64'h4);
        drive_in(64'h0);
        check("R7 edge held after fall", irq_out, 64'h4);
        rd("R9 status edge", 12'h100, 4'd8, 64'h4);
        wr("R6 mask bit2", 12'h020, 4'd1, 64'hF4, 1'b0);
        check("R6 masking drops output", irq_out, 64'h0);
        rd("R9 status gated by mask", 12'h100, 4'd8, 64'h0);
        wr("R6 unmask bit2", 12'h020, 4'd1, 64'hF0, 1'b0);
        check("R6 unmask reasserts", irq_out, 64'h4);
        wr("R9 status write", 12'h100, 4'd8, 64'd0, 1'b0);
        rd("R9 status write ignored", 12'h100, 4'd8, 64'h4);
        wr("R8 clear bit2", 12'h060, 4'd1, 64'h04, 1'b0);
        check("R8 clear drops output", irq_out, 64'h0);
        rd("R8 status after clear", 12'h100, 4'd8, 64'h0);
        drive_in(64'h4);
        check("R7 new edge latched", irq_out, 64'h4);
        wr("R8 clear while held", 12'h060, 4'd1, 64'h04, 1'b0);
        repeat (2) @(negedge clk);
        check("R7 held level no relatch", irq_out, 64'h0);
        drive_in(64'h5);
        check("R8 level bit0 asserted", irq_out, 64'h1);
        wr("R8 clear level bit", 12'h060, 4'd1, 64'h01, 1'b0);
        @(negedge clk);
        check("R8 level bit unaffected", irq_out, 64'h1);
        drive_in(64'h0);
        rd("R8 clear reads zero", 12'h060, 4'd8, 64'd0);
        repeat (3) @(negedge clk);
        check("R5 all responses seen", 64'(q_data.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule